// File: doc/BRIEF.md
# Read-Sequence Mode Switch Detector

This block sits on a 16-bit cartridge bus and watches every halfword read strobe together with its byte offset. Software changes the cartridge's memory mapping by issuing a fixed run of ten reads, a "knock". The eighth read of the knock carries a mode code in its address bits rather than on the data bus. When the tenth read lands, the block loads the new mode into its mapping register. The register drives three mutually exclusive selects: ROM, media interface and RAM, plus a RAM write permission.

Once the ROM mode is loaded, the offsets at and above 0x200 stay locked. They open only after a short follow-on run of four reads. A single magic halfword write gives a shortcut straight into RAM read-write mode. The memories and the media interface are outside this block; it only produces their selects.

Top module: `knock_mode_switch`

## Requirements
- R1: While `rst` is high and after it falls, `sel_rom` is 1, `sel_media`, `sel_ram`, `ram_wr_en` and `hi_unlock` are 0, and the four-read unlock run is not armed.
- R2: The knock is ten consecutive read strobes at byte offsets 0xE00002, 0x00000E, 0x801FFC, 0x00104A, 0x800612, 0x000000, 0x801B66, then a mode read, then 0x00080E and 0x000000. The new mode appears on the outputs from the clock edge that samples the tenth read, and not before it.
- R3: The mode read may be at any even offset, which is twice the mode value. Address bits [4:1] form the code. Code 4 selects ROM, 3 selects the media interface, 2 selects RAM with `ram_wr_en` 0, and 6 selects RAM with `ram_wr_en` 1. Higher code bits are ignored.
- R4: A read that does not match the next expected offset, including an odd mode-read offset, returns the matcher to idle. If that read is at 0xE00002, it counts as the first read of a new knock. A broken knock leaves the outputs unchanged.
- R5: A completed knock whose code is not 2, 3, 4 or 6 leaves the selects, `ram_wr_en` and `hi_unlock` unchanged.
- R6: After the first nine knock reads, the outputs still show the previous mode.
- R7: After a knock loads ROM mode, the next four reads at 0x1E4, 0x1E4, 0x188 and 0x188 set `hi_unlock` on the edge of the fourth read. Any other read in between cancels the run, and `hi_unlock` stays 0 until ROM mode is loaded again.
- R8: A write strobe of data 0xAA55 at byte offset 0x1FFEFFE selects RAM with `ram_wr_en` 1 from that edge on. A write with other data or at another offset has no effect.
- R9: Loading any mode, by knock or by the magic write, clears `hi_unlock`.
- R10: Exactly one of `sel_rom`, `sel_media` and `sel_ram` is 1 at all times. `ram_wr_en` implies `sel_ram`, and `hi_unlock` implies `sel_rom`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle halfword read strobe |
| wr_stb | input | 1 | One-cycle halfword write strobe |
| addr | input | ADDR_W (25) | Byte offset of the access within the cartridge space |
| wdata | input | 16 | Write data |
| sel_rom | output | 1 | ROM mapping selected |
| sel_media | output | 1 | Media interface mapping selected |
| sel_ram | output | 1 | RAM mapping selected |
| ram_wr_en | output | 1 | RAM accepts writes |
| hi_unlock | output | 1 | ROM offsets at or above 0x200 are open |

## Verification
On every cycle, the assertions check several invariants. The select set stays one-hot, and the write and unlock flags stay consistent with it. The mapping holds still whenever neither a completed knock nor a magic write is present. `hi_unlock` rises only on a read, and the matcher's step stays in range. Other behaviour depends on the exact address history and can only be shown by the bench scenarios: that the mode lands on the tenth read's edge and not earlier, that a broken or restarted knock behaves as stated, that unknown codes are ignored, and that an interrupted four-read run keeps the high offsets locked.

// File: rtl/knock_pkg.sv
package knock_pkg;
  localparam int KNOCK_LEN = 10;
  localparam int MODE_STEP = 7;
  localparam int TAIL_LEN  = 4;

  typedef enum logic [1:0] {MAP_ROM = 2'd0, MAP_MEDIA = 2'd1, MAP_RAM = 2'd2} map_e;

  localparam logic [3:0] CODE_ROM    = 4'd4;
  localparam logic [3:0] CODE_MEDIA  = 4'd3;
  localparam logic [3:0] CODE_RAM_RD = 4'd2;
  localparam logic [3:0] CODE_RAM_RW = 4'd6;

  localparam logic [31:0] TAIL_ADDR_A = 32'h0000_01E4;
  localparam logic [31:0] TAIL_ADDR_B = 32'h0000_0188;
  localparam logic [31:0] MAGIC_ADDR  = 32'h01FF_EFFE;
  localparam logic [15:0] MAGIC_DATA  = 16'hAA55;

  // expected byte offset of each knock step; MODE_STEP is a wildcard
  function automatic logic [31:0] knock_addr(input int idx);
    case (idx)
      0:       return 32'h00E0_0002;
      1:       return 32'h0000_000E;
      2:       return 32'h0080_1FFC;
      3:       return 32'h0000_104A;
      4:       return 32'h0080_0612;
      5:       return 32'h0000_0000;
      6:       return 32'h0080_1B66;
      8:       return 32'h0000_080E;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/knock_matcher.sv
module knock_matcher #(
  parameter int ADDR_W = 25,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic [MODE_W-1:0] code
);
  import knock_pkg::*;
  localparam int STEP_W = $clog2(KNOCK_LEN);

  logic [STEP_W-1:0] step;
  logic [31:0]       exp_full;
  logic [31:0]       first_full;
  logic              hit;
  logic              is_first;
  logic              at_last;

  always_comb begin
    exp_full   = knock_addr(int'(step));
    first_full = knock_addr(0);
    at_last    = (step == STEP_W'(KNOCK_LEN - 1));
    is_first   = (addr == first_full[ADDR_W-1:0]);
    if (step == STEP_W'(MODE_STEP)) hit = ~addr[0];
    else                            hit = (addr == exp_full[ADDR_W-1:0]);
    done = rd_stb & hit & at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      code <= '0;
    end else if (rd_stb) begin
      if (hit) begin
        if (step == STEP_W'(MODE_STEP)) code <= addr[MODE_W:1];
        step <= at_last ? '0 : step + 1'b1;
      end else begin
        step <= is_first ? STEP_W'(1) : '0;
      end
    end
  end

  a_r4_step_range: assert property (@(posedge clk) disable iff (rst)
    step < STEP_W'(KNOCK_LEN));
  a_r4_miss_to_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !hit && !is_first) |=> (step == '0));
  a_r2_done_rewinds: assert property (@(posedge clk) disable iff (rst)
    done |=> (step == '0));
endmodule

// File: rtl/knock_mode_reg.sv
module knock_mode_reg #(
  parameter int ADDR_W = 25,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              load,
  input  logic [MODE_W-1:0] code,
  output logic              sel_rom,
  output logic              sel_media,
  output logic              sel_ram,
  output logic              ram_wr_en,
  output logic              hi_unlock
);
  import knock_pkg::*;
  localparam int TC_W = $clog2(TAIL_LEN);

  map_e            map_q;
  logic            wr_q;
  logic            hi_q;
  logic            armed;
  logic [TC_W-1:0] tcnt;
  logic [31:0]     texp;
  logic            magic;

  always_comb begin
    texp  = (int'(tcnt) < TAIL_LEN / 2) ? TAIL_ADDR_A : TAIL_ADDR_B;
    magic = wr_stb && (addr == MAGIC_ADDR[ADDR_W-1:0]) && (wdata == MAGIC_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= MAP_ROM;
      wr_q  <= 1'b0;
      hi_q  <= 1'b0;
      armed <= 1'b0;
      tcnt  <= '0;
    end else begin
      if (rd_stb && armed) begin
        if (addr == texp[ADDR_W-1:0]) begin
          if (tcnt == TC_W'(TAIL_LEN - 1)) begin
            hi_q  <= 1'b1;
            armed <= 1'b0;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end else begin
          armed <= 1'b0;
          tcnt  <= '0;
        end
      end
      if (load) begin
        case (code[3:0])
          CODE_ROM: begin
            map_q <= MAP_ROM;   wr_q <= 1'b0; hi_q <= 1'b0; armed <= 1'b1; tcnt <= '0;
          end
          CODE_MEDIA: begin
            map_q <= MAP_MEDIA; wr_q <= 1'b0; hi_q <= 1'b0; armed <= 1'b0;
          end
          CODE_RAM_RD: begin
            map_q <= MAP_RAM;   wr_q <= 1'b0; hi_q <= 1'b0; armed <= 1'b0;
          end
          CODE_RAM_RW: begin
            map_q <= MAP_RAM;   wr_q <= 1'b1; hi_q <= 1'b0; armed <= 1'b0;
          end
          default: ;
        endcase
      end
      if (magic) begin
        map_q <= MAP_RAM;
        wr_q  <= 1'b1;
        hi_q  <= 1'b0;
        armed <= 1'b0;
        tcnt  <= '0;
      end
    end
  end

  always_comb begin
    sel_rom   = (map_q == MAP_ROM);
    sel_media = (map_q == MAP_MEDIA);
    sel_ram   = (map_q == MAP_RAM);
    ram_wr_en = wr_q;
    hi_unlock = hi_q;
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (rst)
    $countones({sel_rom, sel_media, sel_ram}) == 1);
  a_r10_wr_needs_ram: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> sel_ram);
  a_r10_hi_needs_rom: assert property (@(posedge clk) disable iff (rst)
    hi_unlock |-> sel_rom);
  a_r5_hold_without_cause: assert property (@(posedge clk) disable iff (rst)
    (!load && !magic) |=> ($stable(map_q) && $stable(wr_q)));
  a_r7_rise_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_unlock) |-> $past(rd_stb));
  a_r8_magic_to_rw: assert property (@(posedge clk) disable iff (rst)
    magic |=> (sel_ram && ram_wr_en && !hi_unlock));
endmodule

// File: rtl/knock_mode_switch.sv
module knock_mode_switch #(
  parameter int ADDR_W = 25,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              sel_rom,
  output logic              sel_media,
  output logic              sel_ram,
  output logic              ram_wr_en,
  output logic              hi_unlock
);
  logic              knock_done;
  logic [MODE_W-1:0] knock_code;

  knock_matcher #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_match (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .addr(addr),
    .done(knock_done), .code(knock_code)
  );

  knock_mode_reg #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .load(knock_done), .code(knock_code),
    .sel_rom(sel_rom), .sel_media(sel_media), .sel_ram(sel_ram),
    .ram_wr_en(ram_wr_en), .hi_unlock(hi_unlock)
  );
endmodule

// File: tb/knock_mode_switch_test.sv
`timescale 1ns/1ps
module knock_mode_switch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [24:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        sel_rom, sel_media, sel_ram, ram_wr_en, hi_unlock;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // behavioural reference state
  int K[10] = '{32'hE00002, 32'h00000E, 32'h801FFC, 32'h00104A, 32'h800612,
                32'h000000, 32'h801B66, 0, 32'h00080E, 32'h000000};
  int m_step = 0, m_code = 0, m_sel = 0, m_tcnt = 0;
  bit m_wr = 0, m_hi = 0, m_armed = 0;

  always #10 clk = ~clk;

  knock_mode_switch uut (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .sel_rom(sel_rom), .sel_media(sel_media), .sel_ram(sel_ram),
    .ram_wr_en(ram_wr_en), .hi_unlock(hi_unlock)
  );

  function automatic logic [4:0] outs();
    return {sel_rom, sel_media, sel_ram, ram_wr_en, hi_unlock};
  endfunction

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic apply_code(int c);
    case (c)
      4: begin m_sel = 0; m_wr = 0; m_hi = 0; m_armed = 1; m_tcnt = 0; end
      3: begin m_sel = 1; m_wr = 0; m_hi = 0; m_armed = 0; end
      2: begin m_sel = 2; m_wr = 0; m_hi = 0; m_armed = 0; end
      6: begin m_sel = 2; m_wr = 1; m_hi = 0; m_armed = 0; end
      default: ;
    endcase
  endtask

  task automatic model(bit rd, bit wr, int a, int d);
    if (rd) begin
      if (m_armed) begin
        if (a == ((m_tcnt < 2) ? 32'h1E4 : 32'h188)) begin
          m_tcnt++;
          if (m_tcnt == 4) begin m_hi = 1; m_armed = 0; m_tcnt = 0; end
        end else begin
          m_armed = 0; m_tcnt = 0;
        end
      end
      if ((m_step == 7) ? (a % 2 == 0) : (a == K[m_step])) begin
        if (m_step == 7) m_code = (a >> 1) & 15;
        if (m_step == 9) begin m_step = 0; apply_code(m_code); end
        else m_step++;
      end else begin
        m_step = (a == K[0]) ? 1 : 0;
      end
    end
    if (wr && a == 32'h1FFEFFE && d == 32'hAA55) begin
      m_sel = 2; m_wr = 1; m_hi = 0; m_armed = 0; m_tcnt = 0;
    end
  endtask

  task automatic cyc(bit rd, bit wr, int a, int d);
    rd_stb = rd; wr_stb = wr; addr = a[24:0]; wdata = d[15:0];
    @(posedge clk);
    #1 model(rd, wr, a, d);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    chk(tag, outs(), {m_sel == 0, m_sel == 1, m_sel == 2, m_wr, m_hi});
  endtask

  task automatic rd(int a);
    cyc(1, 0, a, 0);
  endtask

  task automatic knock_part(int mode_addr, int n);
    for (int i = 0; i < n; i++) rd((i == 7) ? mode_addr : K[i]);
  endtask

  task automatic knock(int mode_addr);
    knock_part(mode_addr, 10);
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", outs(), 5'b10000);
    rst = 0;
    @(negedge clk);
    chk("R1", outs(), 5'b10000);
    // R1: unlock run not armed after reset
    tag = "R1";
    rd(32'h1E4); rd(32'h1E4); rd(32'h188); rd(32'h188);
    chk("R1", outs(), 5'b10000);

    // R6 then R2: media code 3
    tag = "R6";
    knock_part(32'h6, 9);
    chk("R6", outs(), 5'b10000);
    tag = "R2";
    rd(32'h0);
    chk("R2", outs(), 5'b01000);

    // R3: code encodings
    tag = "R3";
    knock(32'h4);
    chk("R3", outs(), 5'b00100);
    knock(32'hC);
    chk("R3", outs(), 5'b00110);
    knock(32'h800008);
    chk("R3", outs(), 5'b10000);

    // R7: unlock run
    tag = "R7";
    rd(32'h1E4); rd(32'h1E4); rd(32'h188);
    chk("R7", outs(), 5'b10000);
    rd(32'h188);
    chk("R7", outs(), 5'b10001);

    // R9: new mode clears unlock
    tag = "R9";
    knock(32'h800008);
    chk("R9", outs(), 5'b10000);
    rd(32'h1E4); rd(32'h1E4); rd(32'h188); rd(32'h188);
    knock(32'h6);
    chk("R9", outs(), 5'b01000);

    // R7: interrupted run keeps lock
    tag = "R7";
    knock(32'h8);
    rd(32'h1E4); rd(32'h100); rd(32'h1E4); rd(32'h1E4); rd(32'h188); rd(32'h188);
    chk("R7", outs(), 5'b10000);

    // R4: broken knock, restart, odd mode offset
    tag = "R4";
    knock_part(32'h6, 5);
    rd(32'h123456);
    for (int i = 5; i < 10; i++) rd((i == 7) ? 32'h6 : K[i]);
    chk("R4", outs(), 5'b10000);
    knock_part(32'h6, 3);
    knock(32'h6);
    chk("R4", outs(), 5'b01000);
    knock(32'h9);
    chk("R4", outs(), 5'b01000);

    // R5: unknown codes
    tag = "R5";
    knock(32'hA);
    chk("R5", outs(), 5'b01000);
    knock(32'h0);
    chk("R5", outs(), 5'b01000);

    // R8: magic write and near misses
    tag = "R8";
    knock(32'h8);
    cyc(0, 1, 32'h1FFEFFE, 32'hAA56);
    chk("R8", outs(), 5'b10000);
    cyc(0, 1, 32'h1FFEFFC, 32'hAA55);
    chk("R8", outs(), 5'b10000);
    cyc(0, 1, 32'h1FFEFFE, 32'hAA55);
    chk("R8", outs(), 5'b00110);

    // R10: idle cycles keep consistent outputs
    tag = "R10";
    repeat (4) cyc(0, 0, 0, 0);
    chk("R10", outs(), 5'b00110);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule